// File: doc/BRIEF.md
# I2C Register-Port Target With Word-Length Auto-Increment

This block is an I2C target that lets a host read and write an internal register map through a 16-bit subaddress. It oversamples SCL and SDA with a fast system clock. From the sampled lines it detects START, repeated START and STOP, and it matches the 7-bit device address. The host then sends the subaddress, high byte first. After that the host either streams data bytes for a write, or issues a repeated START with the read bit set so that the target streams bytes back. The target acknowledges each byte it receives. On reads it takes over SDA and shifts data out MSB first.

The register map is reached through a plain synchronous port. Each register is a word of one or more bytes, and a lane index selects a byte within the word. The word length depends on the region the subaddress falls in. The internal pointer moves to the next lane after each byte, and moves to the next subaddress only after the last lane of a word. A received byte is written when its acknowledge starts. A byte to be sent is fetched with a one-cycle read strobe, and its data is expected on the following clock.

Top module: `regport_target`

## Requirements
- R1: On the ninth SCL pulse after a matching address byte, and after every subaddress or data byte it receives, the target pulls SDA low (`sdaOe`=1). It only starts driving SDA while SCL is low.
- R2: A write is START, then the address with R/W=0, then the subaddress high byte, then the subaddress low byte, then data bytes. Each data byte produces exactly one `regWrEn` pulse, which carries the byte on `regWrData` at the current `regAddr`/`regLane`.
- R3: After a repeated START and the address with R/W=1, the target drives each byte MSB first. Each bit is placed on SDA while SCL is low, starting at the falling edge that ends the address acknowledge.
- R4: Every byte to be sent is fetched with one `regRdEn` pulse before its first bit is driven. `regRdData` is taken on the clock after the pulse. The first fetch happens during the acknowledge of the read address.
- R5: The word length comes from subaddress bits [15:12]: 1 gives 2 bytes, 2 gives 4 bytes, 3 gives 5 bytes, and any other value gives 1 byte. Loading a subaddress sets the lane to 0. Each written or fetched byte moves the lane up by one. After the last lane, the lane returns to 0 and the subaddress increments.
- R6: If an address byte does not match, the target does not acknowledge it. Until the next START it neither drives SDA nor pulses `regWrEn` or `regRdEn`.
- R7: When the host does not acknowledge a sent byte, the target releases SDA. It makes no further fetch until a new START.
- R8: A STOP returns the target to idle with SDA released.
- R9: After reset, `sdaOe`, `regWrEn` and `regRdEn` are 0.
- R10: Burst writes and burst reads follow the same pointer rule across word boundaries, in every region type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled I2C clock line |
| sdaIn | input | 1 | Sampled I2C data line |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | 16 | Current subaddress of the register port |
| regLane | output | 3 | Byte lane within the addressed word |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRdEn | output | 1 | One-cycle fetch strobe |
| regRdData | input | 8 | Fetched byte, valid the clock after `regRdEn` |

## Verification
The bench builds the block with device address 0x3A and the default two-stage synchronizer. It uses an SCL quarter period of ten system clocks, so every line change lands well clear of the synchronizer delay. Each transfer length is chosen so that a burst crosses at least one word boundary in the 1-, 2-, 4- and 5-byte regions. This exercises the lane wrap and the subaddress step at every word length. The address 0x3A leaves room for a mismatching address, which shows the ignore path.

// File: rtl/regport_pkg.sv
`timescale 1ns/1ps
package regport_pkg;
  localparam int SUB_W      = 16;
  localparam int LANE_W     = 3;
  localparam int BYTE_W     = 8;
  localparam int REGION_LSB = 12;
  localparam int CNT_W      = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_ACK_RX, S_SEND, S_ACK_TX, S_PRE_SEND, S_WAIT
  } ctlState_t;

  typedef enum logic [1:0] {K_ADDR, K_SUB_HI, K_SUB_LO, K_DATA} byteKind_t;

  typedef struct packed {
    logic clrBits;
    logic sampleBit;
    logic txLoad;
    logic txShift;
    logic subHiLoad;
    logic subLoad;
    logic wrCommit;
    logic rdFetch;
  } ctlStrobe_t;

  // bytes per word for the region holding subaddress a
  function automatic logic [LANE_W-1:0] wordLenOf(input logic [SUB_W-1:0] a);
    case (int'(a[SUB_W-1:REGION_LSB]))
      1:       return LANE_W'(2);
      2:       return LANE_W'(4);
      3:       return LANE_W'(5);
      default: return LANE_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/regport_datapath.sv
`timescale 1ns/1ps
module regport_datapath
  import regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobe_t        strb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [SUB_W-1:0]  regAddr,
  output logic [LANE_W-1:0] regLane,
  output logic [BYTE_W-1:0] regWrData
);
  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclP, sdaP;
  logic [BYTE_W-1:0] rxReg, txReg, hiReg;
  logic [SUB_W-1:0]  subAddr;
  logic [LANE_W-1:0] lane;
  logic              laneLast;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
          sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= sclIn;
          sdaSh <= sdaIn;
        end
      end
    end
  endgenerate

  assign sclS = sclSh[SYNC_STAGES-1];
  assign sdaS = sdaSh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign sdaBit   = sdaS;

  // bit counter and receive shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxReg  <= '0;
    end else if (strb.clrBits) begin
      bitCnt <= '0;
    end else if (strb.sampleBit) begin
      bitCnt <= bitCnt + 1'b1;
      rxReg  <= {rxReg[BYTE_W-2:0], sdaS};
    end
  end

  // transmit shifter
  always_ff @(posedge clk) begin
    if (!rstN)              txReg <= '1;
    else if (strb.txLoad)   txReg <= regRdData;
    else if (strb.txShift)  txReg <= {txReg[BYTE_W-2:0], 1'b1};
  end

  // subaddress pointer with word-length auto-increment
  assign laneLast = (LANE_W'(lane + 1'b1) == wordLenOf(subAddr));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg   <= '0;
      subAddr <= '0;
      lane    <= '0;
    end else begin
      if (strb.subHiLoad) hiReg <= rxReg;
      if (strb.subLoad) begin
        subAddr <= {hiReg, rxReg};
        lane    <= '0;
      end else if (strb.wrCommit || strb.rdFetch) begin
        if (laneLast) begin
          lane    <= '0;
          subAddr <= subAddr + 1'b1;
        end else begin
          lane <= lane + 1'b1;
        end
      end
    end
  end

  assign rxByte    = rxReg;
  assign txMsb     = txReg[BYTE_W-1];
  assign regAddr   = subAddr;
  assign regLane   = lane;
  assign regWrData = rxReg;
endmodule

// File: rtl/regport_control.sv
`timescale 1ns/1ps
module regport_control
  import regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaBit,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output ctlStrobe_t        strb,
  output logic              sdaOe,
  output ctlState_t         ctlState
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  ctlState_t state, stateN;
  byteKind_t kind, kindN;
  logic      rwBit, rwN;
  logic      fetchPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kind      <= K_ADDR;
      rwBit     <= 1'b0;
      fetchPend <= 1'b0;
    end else begin
      state     <= stateN;
      kind      <= kindN;
      rwBit     <= rwN;
      fetchPend <= strb.rdFetch;
    end
  end

  always_comb begin
    stateN      = state;
    kindN       = kind;
    rwN         = rwBit;
    strb        = '0;
    strb.txLoad = fetchPend;
    if (startDet) begin
      stateN       = S_RECV;
      kindN        = K_ADDR;
      rwN          = 1'b0;
      strb.clrBits = 1'b1;
    end else if (stopDet) begin
      stateN = S_IDLE;
    end else begin
      case (state)
        S_RECV: begin
          if (sclRise) begin
            strb.sampleBit = 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            stateN = S_ACK_RX;
            case (kind)
              K_ADDR: begin
                if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                  rwN          = rxByte[0];
                  strb.rdFetch = rxByte[0];
                end else begin
                  stateN = S_WAIT;
                end
              end
              K_SUB_HI: strb.subHiLoad = 1'b1;
              K_SUB_LO: strb.subLoad   = 1'b1;
              default:  strb.wrCommit  = 1'b1;
            endcase
          end
        end
        S_ACK_RX: begin
          if (sclFall) begin
            strb.clrBits = 1'b1;
            if (kind == K_ADDR && rwBit) begin
              stateN = S_SEND;
            end else begin
              stateN = S_RECV;
              case (kind)
                K_ADDR:   kindN = K_SUB_HI;
                K_SUB_HI: kindN = K_SUB_LO;
                default:  kindN = K_DATA;
              endcase
            end
          end
        end
        S_SEND: begin
          if (sclRise) begin
            strb.sampleBit = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) stateN = S_ACK_TX;
            else                    strb.txShift = 1'b1;
          end
        end
        S_ACK_TX: begin
          if (sclRise) begin
            if (!sdaBit) begin
              strb.rdFetch = 1'b1;
              stateN       = S_PRE_SEND;
            end else begin
              stateN = S_WAIT;
            end
          end
        end
        S_PRE_SEND: begin
          if (sclFall) begin
            strb.clrBits = 1'b1;
            stateN       = S_SEND;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe    = (state == S_ACK_RX) || (state == S_SEND && !txMsb);
  assign ctlState = state;
endmodule

// File: rtl/regport_target.sv
`timescale 1ns/1ps
module regport_target
  import regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [SUB_W-1:0]  regAddr,
  output logic [LANE_W-1:0] regLane,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);
  ctlStrobe_t        strb;
  ctlState_t         ctlState;
  logic              sclRise, sclFall, startDet, stopDet, sdaBit, txMsb;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxByte;

  regport_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .bitCnt(bitCnt), .rxByte(rxByte), .txMsb(txMsb),
    .regAddr(regAddr), .regLane(regLane), .regWrData(regWrData)
  );

  regport_control #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .bitCnt(bitCnt), .rxByte(rxByte), .txMsb(txMsb),
    .strb(strb), .sdaOe(sdaOe), .ctlState(ctlState)
  );

  assign regWrEn = strb.wrCommit;
  assign regRdEn = strb.rdFetch;
endmodule

// File: rtl/regport_checks.sv
`timescale 1ns/1ps
module regport_checks
  import regport_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [SUB_W-1:0]  regAddr,
  input logic [LANE_W-1:0] regLane,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic              stopDet,
  input ctlState_t         ctlState
);
  // R1: the target only begins pulling SDA while SCL is low
  p_oe_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R2: a write and a fetch never share a cycle
  p_no_wr_rd_overlap_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R5: lane stays inside the word of the addressed region
  p_lane_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    regLane < wordLenOf(regAddr));

  // R5: after a committed byte the lane steps by one or wraps to zero
  p_lane_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regLane == '0) || (regLane == LANE_W'($past(regLane) + 1'b1)));

  // R6: while ignoring a transaction nothing is driven or strobed
  p_ignore_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == S_WAIT && $past(ctlState) == S_WAIT) |-> (!sdaOe && !regWrEn && !regRdEn));

  // R8: a STOP releases SDA on the next cycle
  p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);
endmodule

bind regport_target regport_checks u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regAddr(regAddr), .regLane(regLane), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .stopDet(stopDet), .ctlState(ctlState)
);

// File: tb/sim_regport_target.sv
`timescale 1ns/1ps
module sim_regport_target;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int NVEC = 5;
  // {subaddress, byte count}
  localparam logic [19:0] VECS [0:NVEC-1] = '{
    {16'h0005, 4'd3}, {16'h1002, 4'd5}, {16'h2001, 4'd6},
    {16'h3000, 4'd7}, {16'h8003, 4'd2}
  };

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, hostLow = 1'b0;
  logic sdaLine, sdaOe, regWrEn, regRdEn;
  logic [15:0] regAddr;
  logic [2:0]  regLane;
  logic [7:0]  regWrData, regRdData;
  logic [7:0]  mem [0:2047];
  int total = 0, bad = 0, wrCnt = 0, rdCnt = 0, oeCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sdaLine = !(hostLow || sdaOe);

  regport_target #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regLane(regLane), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  function automatic int keyOf(logic [15:0] a, logic [2:0] ln);
    return int'({a[15:12], a[3:0], ln});
  endfunction

  function automatic logic [2:0] benchLen(logic [15:0] a);
    case (a[15:12])
      4'h1: return 3'd2;
      4'h2: return 3'd4;
      4'h3: return 3'd5;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] pat(int v, int i);
    return 8'((v * 37 + i * 11 + 28) & 255);
  endfunction

  // register-file model
  always @(posedge clk) begin
    if (regWrEn) begin
      mem[keyOf(regAddr, regLane)] <= regWrData;
      wrCnt <= wrCnt + 1;
    end
    if (regRdEn) begin
      regRdData <= mem[keyOf(regAddr, regLane)];
      rdCnt <= rdCnt + 1;
    end
    if (sdaOe) oeCnt <= oeCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input bit lvl, output bit smp);
    hostLow = !lvl;
    waitQ();
    scl = 1'b1;
    waitQ();
    smp = sdaLine;
    waitQ();
    scl = 1'b0;
    waitQ();
  endtask

  task automatic startCond();
    hostLow = 1'b0; waitQ();
    scl = 1'b1;     waitQ();
    hostLow = 1'b1; waitQ();
    scl = 1'b0;     waitQ();
  endtask

  task automatic stopCond();
    hostLow = 1'b1; waitQ();
    scl = 1'b1;     waitQ();
    hostLow = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit s;
    for (int k = 7; k >= 0; k--) bitCycle(b[k], s);
    bitCycle(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    bit s;
    b = '0;
    for (int k = 0; k < 8; k++) begin
      bitCycle(1'b1, s);
      b = {b[6:0], s};
    end
    bitCycle(!ackIt, s);
  endtask

  task automatic setPointer(input logic [15:0] sub);
    bit ack;
    startCond();
    sendByte({DEV, 1'b0}, ack);  chk(ack, "R1 addr ack", ack, 1);
    sendByte(sub[15:8], ack);    chk(ack, "R1 subaddr high ack", ack, 1);
    sendByte(sub[7:0], ack);     chk(ack, "R1 subaddr low ack", ack, 1);
  endtask

  task automatic runVector(input int v, input logic [15:0] sub, input int cnt);
    logic [15:0] eA [0:15];
    logic [2:0]  eL [0:15];
    logic [15:0] a;
    logic [2:0]  ln;
    logic [7:0]  rb;
    bit ack;
    int wBase, rBase;
    // burst write
    wBase = wrCnt;
    setPointer(sub);
    a = sub; ln = 3'd0;
    for (int i = 0; i < cnt; i++) begin
      eA[i] = a; eL[i] = ln;
      sendByte(pat(v, i), ack);
      chk(ack, "R1 data ack", ack, 1);
      if (3'(ln + 3'd1) == benchLen(a)) begin ln = 3'd0; a = a + 16'd1; end
      else ln = ln + 3'd1;
    end
    stopCond();
    chk(!sdaOe, "R8 released after stop", sdaOe, 0);
    chk(wrCnt == wBase + cnt, "R2 one write per data byte", wrCnt - wBase, cnt);
    for (int i = 0; i < cnt; i++)
      chk(mem[keyOf(eA[i], eL[i])] == pat(v, i), "R5 R10 byte at word/lane",
          mem[keyOf(eA[i], eL[i])], pat(v, i));
    // burst read with repeated START
    setPointer(sub);
    rBase = rdCnt;
    startCond();
    sendByte({DEV, 1'b1}, ack);
    chk(ack, "R3 read address ack", ack, 1);
    chk(rdCnt == rBase + 1, "R4 fetch before first bit", rdCnt - rBase, 1);
    for (int i = 0; i < cnt; i++) begin
      recvByte(i != cnt - 1, rb);
      chk(rb == pat(v, i), "R3 R10 read byte", rb, pat(v, i));
    end
    chk(!sdaOe, "R7 released after host nack", sdaOe, 0);
    waitQ();
    chk(rdCnt == rBase + cnt, "R7 no fetch after nack", rdCnt - rBase, cnt);
    stopCond();
    chk(!sdaOe, "R8 released after stop", sdaOe, 0);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    int wBase, oBase;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    regRdData = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!sdaOe && !regWrEn && !regRdEn, "R9 reset outputs idle",
        {sdaOe, regWrEn, regRdEn}, 0);

    for (int v = 0; v < NVEC; v++)
      runVector(v, VECS[v][19:4], int'(VECS[v][3:0]));

    // R6: mismatching address is ignored until the next START
    wBase = wrCnt; oBase = oeCnt;
    startCond();
    sendByte({7'h11, 1'b0}, ack);
    chk(!ack, "R6 no ack on mismatch", ack, 0);
    sendByte(8'h00, ack);
    sendByte(8'h09, ack);
    sendByte(8'hC3, ack);
    stopCond();
    chk(oeCnt == oBase, "R6 SDA never driven", oeCnt - oBase, 0);
    chk(wrCnt == wBase, "R6 no write", wrCnt - wBase, 0);

    // recovery: single write then single read in a 1-byte region
    setPointer(16'h0009);
    sendByte(8'h5A, ack);
    chk(ack, "R1 single write ack", ack, 1);
    stopCond();
    chk(mem[keyOf(16'h0009, 3'd0)] == 8'h5A, "R2 single write stored",
        mem[keyOf(16'h0009, 3'd0)], 8'h5A);
    setPointer(16'h0009);
    startCond();
    sendByte({DEV, 1'b1}, ack);
    recvByte(1'b0, rb);
    stopCond();
    chk(rb == 8'h5A, "R3 single read", rb, 8'h5A);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule